// File: doc/BRIEF.md
# Smart card character receiver (T=0, convention-aware)

The block is the receive half of an asynchronous smart card UART for the T=0 character protocol, clocked directly from the card clock. While idle it looks at the card I/O line once every `POLL_DIV` clock cycles. The first low sample it sees counts as the leading edge of a start bit. From that moment it counts bit periods of `ETU_CYCLES` clocks and samples every bit halfway through its period. It counts in card clock cycles only, so when the card clock frequency changes, the baud rate stays in a fixed ratio to it.

The first character after reset is the initial character of the Answer To Reset, and its pattern sets the coding convention. Every later character is converted to direct convention before it reaches the host. Each character carries even parity. When the parity check fails, the block pulls the I/O line low for one bit period in the guard time, which asks the card to send the character again, and it does not deliver that byte. The line is assumed to be already synchronous to the card clock. The output `io_pull_low` is meant to drive an open-drain pull-down on the line.

Top module: `card_t0_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_perr`, `io_pull_low` and `conv_err` are 0, the convention is undetermined and the receiver is idle.
- R2: While idle, the line is sampled once every `POLL_DIV` cycles. A low sample starts reception, and a line that stays high never produces an output.
- R3: If the line is high again at the mid-point of the start bit, the event is discarded as a glitch. The receiver goes back to idle with no output and no pull-down.
- R4: Each bit is sampled half a bit period into its slot. A character is a start bit, 8 data bits and one parity bit. In direct convention a high level is a 1, and the first data bit is bit 0 of `rx_data`.
- R5: If the first character decodes to 0x3B in direct convention, direct convention is locked and the byte 0x3B is delivered.
- R6: If the first character decodes to 0x3F under inverse rules (low level is 1, first data bit is bit 7), inverse convention is locked and 0x3F is delivered. Every later byte is complemented and bit-reversed into direct form, and its parity bit is read inverted.
- R7: If the first character matches neither pattern, `conv_err` goes high and stays high until reset, no byte is delivered, and the next character is again treated as the initial one.
- R8: A character whose data bits plus parity bit hold an even number of ones, in the locked convention, gives a one-cycle `rx_valid` pulse carrying the byte. The pulse comes 10.5 bit periods after start detection.
- R9: On a parity failure, `rx_valid` stays low. Instead a one-cycle `rx_perr` pulse is given, and `io_pull_low` is held high for exactly `ETU_CYCLES` cycles, from 10.5 to 11.5 bit periods after start detection.
- R10: Characters whose start bits are 12 bit periods apart are all received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Synchronous active-low reset; also marks the start of the Answer To Reset |
| io_in | input | 1 | Card I/O line level, synchronous to `clk` |
| io_pull_low | output | 1 | Request to pull the I/O line low (repeat request) |
| rx_data | output | 8 | Last delivered byte, in direct convention |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a new good byte |
| rx_perr | output | 1 | One-cycle pulse: a character failed its parity check |
| conv_err | output | 1 | Sticky: an initial character had an unknown pattern |

## Verification
The hardest cases to reach are those that depend on where the poll tick falls relative to the start edge: a start pulse just long enough to be caught by the poll and then rejected as a glitch, and start edges that land at every phase of the poll divider. The bench runs the block with a short bit period and a small poll divider. It inserts a rotating number of idle cycles before each character of a full 256-value sweep. It also drives a low pulse exactly `POLL_DIV` cycles long, so that one poll is certain to catch it and the start-bit mid-point check must reject it. The repeat request is checked by feeding the block's own pull-down back onto the line model and measuring the length of the pulse.

// File: rtl/card_t0_rx_pkg.sv
// Shared types for the smart card character receiver.
package card_t0_rx_pkg;
    // Coding convention of the card, settled by the initial character
    typedef enum logic [1:0] {
        CONV_UNKNOWN = 2'd0,
        CONV_DIRECT  = 2'd1,
        CONV_INVERSE = 2'd2
    } conv_t;

    // Receiver sequencing
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_HOLD = 2'd2
    } rx_state_t;

    // Initial-character values after decoding
    localparam logic [7:0] TS_DIRECT  = 8'h3B;
    localparam logic [7:0] TS_INVERSE = 8'h3F;
endpackage

// File: rtl/card_rx_poll.sv
// Free-running poll divider: a tick once every POLL_DIV clocks.
// Assumes POLL_DIV >= 2.
module card_rx_poll #(
    parameter int POLL_DIV = 31
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(POLL_DIV);
    localparam logic [CW-1:0] LAST = CW'(POLL_DIV - 1);

    logic [CW-1:0] cnt;

    // Count modulo POLL_DIV
    always_ff @(posedge clk) begin
        if (!rst_n || cnt == LAST) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/card_rx_bit_timer.sv
// Bit-period timer. While run is high it counts clocks within a bit period
// and counts bit slots. mid flags the half-period point of the current slot.
// Slot 0 is the start bit. Assumes ETU_CYCLES >= 4.
module card_rx_bit_timer #(
    parameter int ETU_CYCLES = 372
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    output logic       mid,
    output logic [3:0] slot
);
    localparam int PW = $clog2(ETU_CYCLES);
    localparam logic [PW-1:0] LAST = PW'(ETU_CYCLES - 1);
    localparam logic [PW-1:0] HALF = PW'(ETU_CYCLES / 2);

    logic [PW-1:0] phase;

    // Advance the phase and the slot count; clear both while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
            slot  <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
            slot  <= slot + 1'b1;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign mid = run && (phase == HALF);

    // R4: the slot count only moves after a full period has passed
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && slot != $past(slot)) |-> (phase == '0));
endmodule

// File: rtl/card_rx_conv.sv
// Convention decoder. It holds the locked convention and the sticky error
// flag, and it decodes the nine raw line levels (8 data, then parity, oldest
// in bit 0) into a direct-convention byte, a parity verdict and, while the
// convention is unknown, the result of the initial-character check.
module card_rx_conv
    import card_t0_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [8:0] raw,
    input  logic       decide,
    output logic [7:0] byte_out,
    output logic       par_bad,
    output logic       ts_bad,
    output logic       known,
    output logic       conv_err
);
    conv_t       conv;
    conv_t       use_conv;
    logic [7:0]  dir_b, inv_b;
    logic        ones_odd;

    // Inverse form: complement the levels and reverse the bit order
    for (genvar i = 0; i < 8; i++) begin : g_rev
        assign inv_b[7-i] = ~raw[i];
    end
    assign dir_b    = raw[7:0];
    assign ones_odd = ^raw;

    // Choose the convention: the locked one, or the one the pattern implies
    always_comb begin
        use_conv = conv;
        ts_bad   = 1'b0;
        if (conv == CONV_UNKNOWN) begin
            if (dir_b == TS_DIRECT)       use_conv = CONV_DIRECT;
            else if (inv_b == TS_INVERSE) use_conv = CONV_INVERSE;
            else                          ts_bad   = 1'b1;
        end
        byte_out = (use_conv == CONV_INVERSE) ? inv_b : dir_b;
        par_bad  = !ts_bad && ((use_conv == CONV_INVERSE) ? !ones_odd : ones_odd);
    end

    // Lock the convention on a good initial character; latch a bad one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv     <= CONV_UNKNOWN;
            conv_err <= 1'b0;
        end else if (decide && conv == CONV_UNKNOWN) begin
            if (ts_bad)        conv_err <= 1'b1;
            else if (!par_bad) conv     <= use_conv;
        end
    end

    assign known = (conv != CONV_UNKNOWN);

    // R5: once locked, the convention never changes before reset
    conv_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(conv != CONV_UNKNOWN) |-> $stable(conv));
    // R7: the error flag never clears without reset
    conv_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(conv_err) |-> conv_err);
endmodule

// File: rtl/card_t0_rx.sv
// Smart card T=0 character receiver. It detects a start bit by polling,
// samples each bit at mid-period, converts the byte to direct convention,
// checks even parity and raises a repeat request on the line when the check
// fails. Assumes io_in is already synchronous to clk.
module card_t0_rx
    import card_t0_rx_pkg::*;
#(
    parameter int ETU_CYCLES = 372,
    parameter int POLL_DIV   = 31
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_in,
    output logic       io_pull_low,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_perr,
    output logic       conv_err
);
    localparam logic [3:0] SLOT_PAR  = 4'd9;
    localparam logic [3:0] SLOT_DONE = 4'd10;
    localparam logic [3:0] SLOT_END  = 4'd11;

    rx_state_t  state;
    logic       tick, mid, busy;
    logic [3:0] slot;
    logic [8:0] raw;
    logic [7:0] dec_byte;
    logic       par_bad, ts_bad, known, decide;

    assign busy   = (state != ST_IDLE);
    assign decide = (state == ST_RECV) && mid && (slot == SLOT_DONE);

    card_rx_poll #(.POLL_DIV(POLL_DIV)) u_poll (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    card_rx_bit_timer #(.ETU_CYCLES(ETU_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(busy), .mid(mid), .slot(slot)
    );

    card_rx_conv u_conv (
        .clk(clk), .rst_n(rst_n), .raw(raw), .decide(decide),
        .byte_out(dec_byte), .par_bad(par_bad), .ts_bad(ts_bad),
        .known(known), .conv_err(conv_err)
    );

    // Shift in the line level at each data and parity mid-point
    always_ff @(posedge clk) begin
        if (!rst_n)                                          raw <= '1;
        else if (state == ST_RECV && mid && slot != 4'd0 && slot <= SLOT_PAR)
                                                             raw <= {io_in, raw[8:1]};
    end

    // Sequencing: start detect, glitch reject, deliver, repeat request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            io_pull_low <= 1'b0;
            rx_valid    <= 1'b0;
            rx_perr     <= 1'b0;
            rx_data     <= '0;
        end else begin
            rx_valid <= 1'b0;
            rx_perr  <= 1'b0;
            unique case (state)
                ST_IDLE: if (tick && !io_in) state <= ST_RECV;
                ST_RECV: begin
                    if (mid && slot == 4'd0 && io_in) begin
                        state <= ST_IDLE;
                    end else if (decide) begin
                        if (ts_bad) begin
                            state <= ST_IDLE;
                        end else if (par_bad) begin
                            rx_perr     <= 1'b1;
                            io_pull_low <= 1'b1;
                            state       <= ST_HOLD;
                        end else begin
                            rx_valid <= 1'b1;
                            rx_data  <= dec_byte;
                            state    <= ST_IDLE;
                        end
                    end
                end
                ST_HOLD: if (mid && slot == SLOT_END) begin
                    io_pull_low <= 1'b0;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    start_on_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tick && !io_in));
    // R8
    valid_needs_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> known);
    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R9
    pull_with_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_pull_low) |-> (rx_perr && !rx_valid));
    // R9
    no_valid_while_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_pull_low |-> !rx_valid);
endmodule

// File: tb/card_t0_rx_tb_top.sv
module card_t0_rx_tb_top;
    localparam int ETU  = 32;
    localparam int POLL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lvl = 1'b1;
    logic io_pull_low, rx_valid, rx_perr, conv_err;
    logic [7:0] rx_data;
    wire  io_line = lvl & ~io_pull_low;

    int checks = 0, fails = 0;
    int vcnt = 0, pcnt = 0, run_len = 0, last_len = 0;
    logic [7:0] last_data = '0;
    bit done = 0;

    always #5 clk = ~clk;

    card_t0_rx #(.ETU_CYCLES(ETU), .POLL_DIV(POLL)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_in(io_line), .io_pull_low(io_pull_low),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr),
        .conv_err(conv_err)
    );

    // Output monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin vcnt++; last_data = rx_data; end
            if (rx_perr) pcnt++;
            if (io_pull_low) run_len++;
            else if (run_len != 0) begin last_len = run_len; run_len = 0; end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Line levels for a byte: bits 0..7 data, bit 8 parity
    function automatic logic [8:0] enc(input logic [7:0] b, input bit inv, input bit bad_par);
        logic [8:0] r;
        for (int i = 0; i < 8; i++) r[i] = inv ? ~b[7-i] : b[i];
        r[8] = (inv ? ~(^b) : (^b)) ^ bad_par;
        return r;
    endfunction

    // One character: start, 9 bits, two high guard periods
    task automatic send(input logic [8:0] r, input int pre);
        repeat (pre) @(negedge clk);
        lvl = 1'b0;
        repeat (ETU) @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            lvl = r[i];
            repeat (ETU) @(negedge clk);
        end
        lvl = 1'b1;
        repeat (2 * ETU) @(negedge clk);
    endtask

    task automatic do_reset();
        lvl = 1'b1;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic expect_byte(input logic [7:0] b, input string req, input int v0);
        chk(vcnt == v0 + 1, req, vcnt, v0 + 1);
        chk(last_data == b, req, last_data, b);
    endtask

    initial begin
        int v0, p0;
        do_reset();
        // R1
        chk(!rx_valid && !rx_perr && !io_pull_low && !conv_err, "R1 reset outputs",
            {rx_valid, rx_perr, io_pull_low, conv_err}, 0);
        // R2: high line never triggers
        repeat (20 * ETU) @(negedge clk);
        chk(vcnt == 0 && pcnt == 0, "R2 idle line", vcnt + pcnt, 0);

        // R5: direct initial character
        v0 = vcnt; send(enc(8'h3B, 0, 0), 0); expect_byte(8'h3B, "R5 direct TS", v0);
        // R4 R10 R2: full sweep, 12-period spacing, rotating start phase
        for (int b = 0; b < 256; b++) begin
            v0 = vcnt;
            send(enc(8'(b), 0, 0), b % 5);
            expect_byte(8'(b), "R4/R10 direct sweep", v0);
        end
        // R9: parity error then repeat
        v0 = vcnt; p0 = pcnt;
        send(enc(8'hA5, 0, 1), 1);
        chk(vcnt == v0, "R9 no valid on parity error", vcnt, v0);
        chk(pcnt == p0 + 1, "R9 perr pulse", pcnt, p0 + 1);
        chk(last_len == ETU, "R9 pull-low length", last_len, ETU);
        v0 = vcnt; send(enc(8'hA5, 0, 0), 0); expect_byte(8'hA5, "R8 repeated byte", v0);
        // R3: glitch caught by one poll then rejected
        v0 = vcnt; p0 = pcnt;
        lvl = 1'b0; repeat (POLL) @(negedge clk); lvl = 1'b1;
        repeat (12 * ETU) @(negedge clk);
        chk(vcnt == v0 && pcnt == p0 && !io_pull_low, "R3 glitch ignored", vcnt - v0 + pcnt - p0, 0);
        v0 = vcnt; send(enc(8'h5A, 0, 0), 2); expect_byte(8'h5A, "R3 receive after glitch", v0);

        // R6: inverse convention
        do_reset();
        v0 = vcnt; send(enc(8'h3F, 1, 0), 0); expect_byte(8'h3F, "R6 inverse TS", v0);
        for (int k = 0; k < 24; k++) begin
            logic [7:0] b = 8'((k * 37 + 11) & 8'hFF);
            v0 = vcnt;
            send(enc(b, 1, 0), k % 4);
            expect_byte(b, "R6 inverse conversion", v0);
        end
        v0 = vcnt; p0 = pcnt;
        send(enc(8'h81, 1, 1), 0);
        chk(vcnt == v0 && pcnt == p0 + 1, "R9 inverse parity error", pcnt - p0, 1);
        chk(last_len == ETU, "R9 inverse pull-low length", last_len, ETU);

        // R7: unknown initial character
        do_reset();
        v0 = vcnt; p0 = pcnt;
        send(enc(8'h55, 0, 0), 0);
        chk(conv_err == 1'b1, "R7 conv_err set", conv_err, 1);
        chk(vcnt == v0 && pcnt == p0, "R7 no delivery", vcnt - v0, 0);
        v0 = vcnt; send(enc(8'h3B, 0, 0), 0); expect_byte(8'h3B, "R7 retry as TS", v0);
        chk(conv_err == 1'b1, "R7 conv_err sticky", conv_err, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R10 watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule